// File: doc/BRIEF.md
# Colour LCD Controller Register Block

This block is the software-visible register file of a colour LCD controller. It sits on a simple 32-bit peripheral bus that addresses a 4 KB window one word at a time. It holds four panel timing words, the frame base addresses for the upper and lower panel halves, a control word, an interrupt mask and a sticky status word. Status bits are cleared by writing ones to a clear register. It drives the settings the rest of the controller needs: the enable flag, the pixel depth code, both base addresses and the active width and height decoded from the timing words. It also drives a level interrupt.

A frame-tick input, nominally at 60 Hz, stands for the vertical blanking event. While the controller is enabled, each tick raises both the next-base status bit and the vertical-compare status bit. A 128-word palette window inside the bus window is forwarded to a separate palette RAM: index, write data and a read strobe go out, and the read data comes back one cycle later. The top of the window holds eight read-only identification bytes.

The parameter `VARIANT` selects between two register layouts. Variant 0 has the control word at word 6 and the mask at word 7. Variant 1 swaps those two words and returns a different identification sequence.

Top module: `lcdc_regs`

## Requirements
- R1: While `rst` is high, and after it falls, every register, `bus_rdata`, `irq`, `lcd_on` and the status read back as zero.
- R2: Words 0 to 3 (timing) and words 4 and 5 (upper and lower base) store a full 32-bit write. A read of any word returns its data on `bus_rdata` in the cycle after the read request. `upper_base` and `lower_base` follow words 4 and 5.
- R3: With `VARIANT`=0, word 6 is the control word (16 bits stored) and word 7 is the mask (5 bits stored). With `VARIANT`=1 the two addresses are exchanged.
- R4: Word 8 reads the raw 5-bit status. Word 9 reads the status ANDed with the mask.
- R5: A write to word 10 clears each status bit whose write-data bit is 1. If a frame tick lands in the same cycle, the bits it sets stay set.
- R6: `irq` is high in exactly the cycles in which status AND mask is nonzero, and it changes on the same clock edge as those registers.
- R7: `lcd_on` is control bit 0 AND control bit 11. `pix_depth` is control bits 3:1.
- R8: `act_width` is ((timing0 & 0xFC) + 4) * 4 and `act_height` is (timing1 & 0x3FF) + 1.
- R9: A `frame_tick` while `lcd_on` is high sets status bit 2 and status bit 3 together. A tick while `lcd_on` is low changes nothing.
- R10: Words 1016 to 1023 (byte offsets 0xFE0 to 0xFFC) read one identification byte each, index = word - 1016. Variant 0 returns 10 11 04 00 0D F0 05 B1 (hex). Variant 1 returns 11 11 24 00 0D F0 05 B1.
- R11: Reads of word 10, words 11 and 12, and any other word outside the map return zero. Writes there change no register.
- R12: Words 128 to 255 form the palette window. A write there drives `pal_we` with `pal_idx` = word - 128 and the write data. A read drives `pal_re`, and `bus_rdata` carries `pal_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address (byte address bits 11:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| frame_tick | input | 1 | One-cycle vertical blanking pulse |
| pal_re | output | 1 | Palette read strobe |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette entry index |
| pal_wdata | output | 32 | Palette write data |
| pal_rdata | input | 32 | Palette data, one cycle after `pal_re` |
| lcd_on | output | 1 | Controller enabled and powered |
| pix_depth | output | 3 | Pixel depth code |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| act_width | output | 11 | Active pixels per line |
| act_height | output | 11 | Active lines per frame |
| irq | output | 1 | Level interrupt |

## Verification
A wrong status or mask bit shows up on `irq` at the very edge where the register takes it. It also shows up on the raw and masked reads one cycle after a read request. A stuck enable decode shows up as a frame tick that sets no status bits, or that sets them while the controller is off. A misplaced write strobe corrupts whichever register it wrongly hits, and that register's next read back shows the damage. The bench keeps a behavioural model of both layouts and compares every output on every cycle, so most faults are caught within one or two cycles of the first stimulus that reaches them.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  // Register word offsets whose positions software depends on
  localparam int WORD_TIM_LAST = 3;
  localparam int WORD_UBASE    = 4;
  localparam int WORD_LBASE    = 5;
  localparam int WORD_SLOT_A   = 6;
  localparam int WORD_SLOT_B   = 7;
  localparam int WORD_RAW      = 8;
  localparam int WORD_MIS      = 9;
  localparam int WORD_CLR      = 10;
  localparam int ID_BYTES      = 8;

  // Status bit positions raised by a frame tick
  localparam int BIT_NEXTBASE  = 2;
  localparam int BIT_VCOMP     = 3;

  // Control bit positions
  localparam int CB_ENABLE     = 0;
  localparam int CB_POWER      = 11;
  localparam int CB_DEPTH_LO   = 1;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TIM,
    SEL_UBASE,
    SEL_LBASE,
    SEL_CTRL,
    SEL_MASK,
    SEL_RAW,
    SEL_MIS,
    SEL_CLR,
    SEL_PAL,
    SEL_ID
  } sel_e;
endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
  import lcdc_pkg::*;
#(
  parameter int WA_W      = 10,
  parameter int PAL_BASE  = 128,
  parameter int PAL_DEPTH = 128,
  parameter int VARIANT   = 0,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int ID_AW    = $clog2(ID_BYTES)
) (
  input  logic [WA_W-1:0]   word,
  output sel_e              sel,
  output logic [1:0]        tim_idx,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [ID_AW-1:0]  id_idx
);
  localparam int WORDS   = 1 << WA_W;
  localparam int ID_BASE = WORDS - ID_BYTES;
  localparam logic [WA_W-1:0] PAL_LO = WA_W'(PAL_BASE);
  localparam logic [WA_W-1:0] PAL_HI = WA_W'(PAL_BASE + PAL_DEPTH - 1);
  localparam logic [WA_W-1:0] ID_LO  = WA_W'(ID_BASE);

  // The layout parameter decides which of the two slots holds control
  sel_e slot_a_sel, slot_b_sel;
  generate
    if (VARIANT == 0) begin : g_orig
      assign slot_a_sel = SEL_CTRL;
      assign slot_b_sel = SEL_MASK;
    end else begin : g_swap
      assign slot_a_sel = SEL_MASK;
      assign slot_b_sel = SEL_CTRL;
    end
  endgenerate

  logic [WA_W-1:0] pal_off, id_off;
  assign pal_off = word - PAL_LO;
  assign id_off  = word - ID_LO;
  assign tim_idx = word[1:0];
  assign pal_idx = pal_off[PAL_AW-1:0];
  assign id_idx  = id_off[ID_AW-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (word <= WA_W'(WORD_TIM_LAST))      sel = SEL_TIM;
    else if (word == WA_W'(WORD_UBASE))    sel = SEL_UBASE;
    else if (word == WA_W'(WORD_LBASE))    sel = SEL_LBASE;
    else if (word == WA_W'(WORD_SLOT_A))   sel = slot_a_sel;
    else if (word == WA_W'(WORD_SLOT_B))   sel = slot_b_sel;
    else if (word == WA_W'(WORD_RAW))      sel = SEL_RAW;
    else if (word == WA_W'(WORD_MIS))      sel = SEL_MIS;
    else if (word == WA_W'(WORD_CLR))      sel = SEL_CLR;
    else if (word >= PAL_LO && word <= PAL_HI) sel = SEL_PAL;
    else if (word >= ID_LO)                sel = SEL_ID;
  end
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 11
) (
  input  logic [DATA_W-1:0] tim0,
  input  logic [DATA_W-1:0] tim1,
  output logic [DIM_W-1:0]  width,
  output logic [DIM_W-1:0]  height
);
  // ((t0 & 0xFC) + 4) * 4 equals (t0[7:2] + 1) * 16
  logic [6:0] groups;
  assign groups = {1'b0, tim0[7:2]} + 7'd1;
  assign width  = DIM_W'({groups, 4'b0000});
  assign height = DIM_W'({1'b0, tim1[9:0]} + 11'd1);
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl
  import lcdc_pkg::*;
#(
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] clr_bits,
  input  logic              tick_ok,
  output logic [STAT_W-1:0] stat_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq
);
  logic [STAT_W-1:0] set_bits, stat_d, mask_d;

  always_comb begin
    set_bits = '0;
    if (tick_ok) begin
      set_bits[BIT_NEXTBASE] = 1'b1;
      set_bits[BIT_VCOMP]    = 1'b1;
    end
    // the clear goes first, so bits set by a tick in the same cycle stay set
    stat_d = (stat_q & ~(clr_we ? clr_bits : '0)) | set_bits;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= |(stat_d & mask_d);
    end
  end
endmodule

// File: rtl/lcdc_id_rom.sv
module lcdc_id_rom
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0,
  localparam int ID_AW  = $clog2(ID_BYTES)
) (
  input  logic [ID_AW-1:0] idx,
  output logic [7:0]       id_byte
);
  logic [7:0] first, third;
  generate
    if (VARIANT == 0) begin : g_v0
      assign first = 8'h10;
      assign third = 8'h04;
    end else begin : g_v1
      assign first = 8'h11;
      assign third = 8'h24;
    end
  endgenerate

  always_comb begin
    case (idx)
      3'd0:    id_byte = first;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = third;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  end
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int CTRL_W    = 16,
  parameter int STAT_W    = 5,
  parameter int PAL_BASE  = 128,
  parameter int PAL_DEPTH = 128,
  parameter int DIM_W     = 11,
  parameter int VARIANT   = 0,
  localparam int WA_W     = ADDR_W - 2,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int ID_AW    = $clog2(ID_BYTES),
  localparam int N_TIM    = WORD_TIM_LAST + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:2] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_tick,
  output logic              pal_re,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_idx,
  output logic [DATA_W-1:0] pal_wdata,
  input  logic [DATA_W-1:0] pal_rdata,
  output logic              lcd_on,
  output logic [2:0]        pix_depth,
  output logic [DATA_W-1:0] upper_base,
  output logic [DATA_W-1:0] lower_base,
  output logic [DIM_W-1:0]  act_width,
  output logic [DIM_W-1:0]  act_height,
  output logic              irq
);
  sel_e             sel;
  logic [1:0]       tim_idx;
  logic [ID_AW-1:0] id_idx;
  logic [7:0]       id_byte;
  logic             wr_cyc, rd_cyc;

  logic [DATA_W-1:0] tim_q [N_TIM];
  logic [DATA_W-1:0] ubase_q, lbase_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:0] stat_q, mask_q;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic              pal_rd_q;
  logic              tick_gated, clr_we, mask_we;

  assign wr_cyc = bus_sel &&  bus_wr;
  assign rd_cyc = bus_sel && !bus_wr;

  lcdc_addr_dec #(
    .WA_W(WA_W), .PAL_BASE(PAL_BASE), .PAL_DEPTH(PAL_DEPTH), .VARIANT(VARIANT)
  ) u_dec (
    .word(bus_addr), .sel(sel), .tim_idx(tim_idx), .pal_idx(pal_idx), .id_idx(id_idx)
  );

  lcdc_id_rom #(.VARIANT(VARIANT)) u_id (.idx(id_idx), .id_byte(id_byte));

  // Timing words: one register per word, written through a generate loop
  generate
    for (genvar gi = 0; gi < N_TIM; gi++) begin : g_tim
      always_ff @(posedge clk) begin
        if (rst)                                     tim_q[gi] <= '0;
        else if (wr_cyc && sel == SEL_TIM && tim_idx == 2'(gi)) tim_q[gi] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_cyc) begin
      if (sel == SEL_UBASE) ubase_q <= bus_wdata;
      if (sel == SEL_LBASE) lbase_q <= bus_wdata;
      if (sel == SEL_CTRL)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
    end
  end

  assign lcd_on     = ctrl_q[CB_ENABLE] & ctrl_q[CB_POWER];
  assign pix_depth  = ctrl_q[CB_DEPTH_LO +: 3];
  assign upper_base = ubase_q;
  assign lower_base = lbase_q;
  assign tick_gated = frame_tick && lcd_on;
  assign clr_we     = wr_cyc && sel == SEL_CLR;
  assign mask_we    = wr_cyc && sel == SEL_MASK;

  lcdc_irq_ctrl #(.STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst(rst),
    .mask_we(mask_we), .mask_wdata(bus_wdata[STAT_W-1:0]),
    .clr_we(clr_we), .clr_bits(bus_wdata[STAT_W-1:0]),
    .tick_ok(tick_gated),
    .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  lcdc_geom #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_geom (
    .tim0(tim_q[0]), .tim1(tim_q[1]), .width(act_width), .height(act_height)
  );

  // Palette window is forwarded; its data is muxed in one cycle later
  assign pal_we    = wr_cyc && sel == SEL_PAL;
  assign pal_re    = rd_cyc && sel == SEL_PAL;
  assign pal_wdata = bus_wdata;

  always_comb begin
    rd_d = '0;
    case (sel)
      SEL_TIM:   rd_d = tim_q[tim_idx];
      SEL_UBASE: rd_d = ubase_q;
      SEL_LBASE: rd_d = lbase_q;
      SEL_CTRL:  rd_d = DATA_W'(ctrl_q);
      SEL_MASK:  rd_d = DATA_W'(mask_q);
      SEL_RAW:   rd_d = DATA_W'(stat_q);
      SEL_MIS:   rd_d = DATA_W'(stat_q & mask_q);
      SEL_ID:    rd_d = DATA_W'(id_byte);
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      pal_rd_q <= 1'b0;
    end else begin
      rd_q     <= rd_cyc ? rd_d : '0;
      pal_rd_q <= pal_re;
    end
  end

  assign bus_rdata = pal_rd_q ? pal_rdata : rd_q;
endmodule

// File: rtl/lcdc_regs_chk.sv
module lcdc_regs_chk #(
  parameter int STAT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_ok,
  input logic              clr_we,
  input logic [STAT_W-1:0] clr_bits,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] mask,
  input logic              irq
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (stat == '0 && mask == '0 && !irq)); // R1

  AST_IRQ_TRACKS_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq == (|(stat & mask))); // R6

  AST_TICK_SETS_PAIR: assert property (@(posedge clk) disable iff (rst)
    tick_ok |=> (stat[2] && stat[3])); // R9

  AST_CLEAR_DROPS_BITS: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !tick_ok) |=> ((stat & $past(clr_bits)) == '0)); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !tick_ok |=> ((stat & ~$past(stat)) == '0)); // R9
endmodule

bind lcdc_regs lcdc_regs_chk #(.STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .tick_ok(tick_gated), .clr_we(clr_we),
  .clr_bits(bus_wdata[STAT_W-1:0]), .stat(stat_q), .mask(mask_q), .irq(irq)
);

// File: tb/sim_lcdc_regs.sv
module sim_lcdc_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        bus_sel = 0, bus_wr = 0, frame_tick = 0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;

  logic [31:0] rdata [2];
  logic        pre [2], pwe [2], on [2], irqo [2];
  logic [6:0]  pidx [2];
  logic [31:0] pwd [2], prd [2], ubo [2], lbo [2];
  logic [2:0]  dep [2];
  logic [10:0] wid [2], hei [2];

  lcdc_regs #(.VARIANT(0)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .frame_tick(frame_tick),
    .pal_re(pre[0]), .pal_we(pwe[0]), .pal_idx(pidx[0]), .pal_wdata(pwd[0]),
    .pal_rdata(prd[0]), .lcd_on(on[0]), .pix_depth(dep[0]), .upper_base(ubo[0]),
    .lower_base(lbo[0]), .act_width(wid[0]), .act_height(hei[0]), .irq(irqo[0]));

  lcdc_regs #(.VARIANT(1)) u1 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .frame_tick(frame_tick),
    .pal_re(pre[1]), .pal_we(pwe[1]), .pal_idx(pidx[1]), .pal_wdata(pwd[1]),
    .pal_rdata(prd[1]), .lcd_on(on[1]), .pix_depth(dep[1]), .upper_base(ubo[1]),
    .lower_base(lbo[1]), .act_width(wid[1]), .act_height(hei[1]), .irq(irqo[1]));

  // Palette RAM stand-ins, one cycle read latency
  logic [31:0] pram [2][128];
  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (pwe[v]) pram[v][pidx[v]] <= pwd[v];
      if (pre[v]) prd[v] <= pram[v][pidx[v]];
    end
  end

  int checks = 0, fails = 0;
  bit started = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_tim [2][4];
  logic [31:0] m_ub [2], m_lb [2], m_ctrl [2], m_mask [2], m_stat [2], m_rd [2];
  logic [31:0] m_pal [2][128];

  function automatic logic [7:0] id_val(int v, int i);
    logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v == 1 && i == 0) return 8'h11;
    if (v == 1 && i == 2) return 8'h24;
    return t[i];
  endfunction

  function automatic int ctrl_word(int v); return (v == 0) ? 6 : 7; endfunction
  function automatic int mask_word(int v); return (v == 0) ? 7 : 6; endfunction

  function automatic logic [31:0] m_read(int v, int w);
    if (w < 4) return m_tim[v][w];
    if (w == 4) return m_ub[v];
    if (w == 5) return m_lb[v];
    if (w == ctrl_word(v)) return m_ctrl[v];
    if (w == mask_word(v)) return m_mask[v];
    if (w == 8) return m_stat[v];
    if (w == 9) return m_stat[v] & m_mask[v];
    if (w >= 128 && w < 256) return m_pal[v][w - 128];
    if (w >= 1016) return {24'h0, id_val(v, w - 1016)};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (rst) begin
        for (int i = 0; i < 4; i++) m_tim[v][i] = 0;
        m_ub[v] = 0; m_lb[v] = 0; m_ctrl[v] = 0; m_mask[v] = 0; m_stat[v] = 0; m_rd[v] = 0;
      end else begin
        int w;
        bit en;
        w = bus_addr;
        en = m_ctrl[v][0] && m_ctrl[v][11];
        m_rd[v] = (bus_sel && !bus_wr) ? m_read(v, w) : 0;
        if (bus_sel && bus_wr) begin
          if (w < 4) m_tim[v][w] = bus_wdata;
          else if (w == 4) m_ub[v] = bus_wdata;
          else if (w == 5) m_lb[v] = bus_wdata;
          else if (w == ctrl_word(v)) m_ctrl[v] = bus_wdata & 32'hFFFF;
          else if (w == mask_word(v)) m_mask[v] = bus_wdata & 32'h1F;
          else if (w == 10) m_stat[v] = m_stat[v] & ~bus_wdata;
          else if (w >= 128 && w < 256) m_pal[v][w - 128] = bus_wdata;
        end
        if (frame_tick && en) m_stat[v] = m_stat[v] | 32'h0C;
      end
    end
    started = 1;
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      for (int v = 0; v < 2; v++) begin
        chk($sformatf("R2 rdata v%0d", v), rdata[v], m_rd[v]);
        chk($sformatf("R6 irq v%0d", v), {31'h0, irqo[v]}, {31'h0, |(m_stat[v] & m_mask[v])});
        chk($sformatf("R7 lcd_on v%0d", v), {31'h0, on[v]}, {31'h0, m_ctrl[v][0] & m_ctrl[v][11]});
        chk($sformatf("R7 depth v%0d", v), {29'h0, dep[v]}, {29'h0, m_ctrl[v][3:1]});
        chk($sformatf("R8 width v%0d", v), {21'h0, wid[v]}, ((m_tim[v][0] & 32'hFC) + 4) * 4);
        chk($sformatf("R8 height v%0d", v), {21'h0, hei[v]}, (m_tim[v][1] & 32'h3FF) + 1);
        chk($sformatf("R2 bases v%0d", v), ubo[v] ^ lbo[v], m_ub[v] ^ m_lb[v]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0; frame_tick = 0;
  endtask

  task automatic wr(input int w, input logic [31:0] d, input bit tk = 0);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = 10'(w); bus_wdata = d; frame_tick = tk;
    @(negedge clk); #1;
    bus_sel = 0; bus_wr = 0; frame_tick = 0;
  endtask

  // issue a read; data is visible at the following negedge
  task automatic rd(input int w, output logic [31:0] d0, output logic [31:0] d1);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = 10'(w);
    @(negedge clk);
    d0 = rdata[0]; d1 = rdata[1];
    #1; bus_sel = 0;
  endtask

  task automatic tick();
    @(negedge clk); #1; frame_tick = 1;
    @(negedge clk); #1; frame_tick = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    int unsigned lf = 32'hACE1;
    repeat (4) @(negedge clk);
    chk("R1 reset rdata", rdata[0], 0);
    chk("R1 reset irq", {31'h0, irqo[0]}, 0);
    #1; rst = 0;
    idle();
    rd(8, a, b); chk("R1 status after reset", a, 0);

    // timing and bases
    wr(0, 32'h0000_003C); wr(1, 32'h0000_01DF); wr(2, 32'h1234_5678); wr(3, 32'hCAFE_0001);
    wr(4, 32'h8000_0000); wr(5, 32'h8004_B000);
    chk("R8 width 256", {21'h0, wid[0]}, 256);
    chk("R8 height 480", {21'h0, hei[0]}, 480);
    rd(2, a, b); chk("R2 timing2", a, 32'h1234_5678);
    rd(5, a, b); chk("R2 lower base", a, 32'h8004_B000);
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    chk("R8 width max", {21'h0, wid[0]}, 1024);
    chk("R8 height max", {21'h0, hei[0]}, 1024);

    // control and mask in each layout
    wr(6, 32'h0000_080B); wr(7, 32'h0000_000C);
    chk("R3 v0 enabled", {31'h0, on[0]}, 1);
    chk("R3 v1 not enabled", {31'h0, on[1]}, 0);
    chk("R7 depth 5", {29'h0, dep[0]}, 5);
    rd(7, a, b); chk("R3 v0 word7 mask", a, 32'h0C); chk("R3 v1 word7 ctrl", b, 32'h0C);
    rd(6, a, b); chk("R3 v1 word6 mask", b, 32'h0B);

    // frame tick
    tick();
    chk("R9 tick raises irq", {31'h0, irqo[0]}, 1);
    chk("R9 tick ignored when off", {31'h0, irqo[1]}, 0);
    rd(8, a, b); chk("R4 raw", a, 32'h0C); chk("R9 v1 raw untouched", b, 0);
    wr(6, 32'h0000_0003);
    rd(9, a, b); chk("R4 masked", a, 32'h0C);
    wr(10, 32'h0000_0004);
    rd(8, a, b); chk("R5 partial clear", a, 32'h08);
    wr(10, 32'h0000_001F);
    chk("R6 irq drops", {31'h0, irqo[0]}, 0);
    wr(6, 32'h0000_0801);
    wr(10, 32'h0000_000C, 1);
    rd(8, a, b); chk("R5 tick wins over clear", a, 32'h0C);
    wr(7, 32'h0);
    chk("R6 mask off lowers irq", {31'h0, irqo[0]}, 0);

    // undefined offsets
    wr(11, 32'hFFFF_FFFF); wr(12, 32'hFFFF_FFFF); wr(40, 32'hFFFF_FFFF); wr(600, 32'hFFFF_FFFF);
    rd(10, a, b); chk("R11 clear reads zero", a, 0);
    rd(12, a, b); chk("R11 word12 zero", a, 0);
    rd(600, a, b); chk("R11 hole zero", a, 0);
    rd(4, a, b); chk("R11 base intact", a, 32'h8000_0000);

    // palette forwarding
    wr(133, 32'h00AB_CDEF);
    rd(133, a, b); chk("R12 palette readback", a, 32'h00AB_CDEF);
    wr(255, 32'h1357_9BDF);
    rd(255, a, b); chk("R12 last palette entry", b, 32'h1357_9BDF);

    // identification bytes
    for (int i = 0; i < 8; i++) begin
      rd(1016 + i, a, b);
      chk($sformatf("R10 id%0d v0", i), a, {24'h0, id_val(0, i)});
      chk($sformatf("R10 id%0d v1", i), b, {24'h0, id_val(1, i)});
    end

    // mixed traffic, checked by the per-cycle model
    for (int n = 0; n < 600; n++) begin
      int w, op;
      lf = lf * 32'd1103515245 + 32'd12345;
      op = (lf >> 16) % 6;
      w = (lf >> 8) % 16;
      if ((lf & 32'h7) == 0) w = 128 + ((lf >> 4) % 128);
      if ((lf & 32'h1F) == 1) w = 1016 + ((lf >> 4) % 8);
      case (op)
        0, 1: wr(w, lf ^ 32'h0000_0801);
        2: rd(w, a, b);
        3: tick();
        4: wr(10, lf >> 3, 1);
        default: idle();
      endcase
    end

    idle(); idle();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule